// File: doc/BRIEF.md
# Spread-Spectrum Divider Modulator

This block adds a slow triangular offset to the feedback divider value of a clock synthesizer loop. Spreading the output frequency this way lowers the peak of its emission spectrum. A timebase tick, nominally one every 280 ns, advances a dwell counter. Each time the count reaches the programmed dwell value, the signed offset moves by one step. The offset is added to a base divider value N, and the sum goes to the downstream divider.

Two fields set the excursion limits, one for the upward side and one for the downward side. Each field holds the negative of the wanted magnitude in two's complement. In down-spread mode the offset swings between zero and minus the down magnitude. In center-spread mode it swings between plus the up magnitude and minus the down magnitude.

Clearing the enable, or changing the mode, sends the offset back to zero at the next step boundary. The walk then restarts in the downward direction. The field width is a parameter, so one loop can use 4-bit fields and another can use 6-bit fields.

Top module: `ss_divider_mod`

## Requirements
- R1: After reset, and at any time while reset is held, the offset is 0 and the divider output equals the parameter RST_N (default 890).
- R2: The magnitude of each excursion field is its two's-complement negation, taken modulo 2^STEP_W. For STEP_W=4: 4'b1111 gives 1, 4'b1101 gives 3, 4'b1000 gives 8 and 4'b0000 gives 0.
- R3: A step boundary is the tick on which the dwell counter has reached the dwell field, so each step lasts dwell+1 ticks. The counter then restarts from 0. Nothing changes in cycles without a tick.
- R4: In down-spread mode (center input 0), the offset starts at 0 and moves down one unit per boundary to minus the down magnitude. It then moves up to 0 and turns down again. Each turnaround takes effect on the same boundary, so every boundary moves the offset.
- R5: In center-spread mode (center input 1), the offset moves between plus the up magnitude and minus the down magnitude by one unit per boundary. It starts downward from 0.
- R6: While the enable input is 0, each boundary forces the offset to 0 and it stays there. After the enable returns to 1, the next boundary moves the offset to -1 (when the down magnitude is nonzero).
- R7: When the center input differs from the mode in use, the next boundary sets the offset to 0 and adopts the new mode. The boundary after that starts the walk downward. Reset selects down-spread.
- R8: The divider output equals the base N sampled at the last boundary plus the sign-extended offset. A change of the base input shows only after the next boundary.
- R9: With STEP_W=6 the same rules hold: 6'b111000 gives a magnitude of 8, 6'b111111 gives 1 and 6'b111110 gives 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one-cycle pulse |
| ss_en_i | input | 1 | Modulation enable |
| center_i | input | 1 | 0 selects down spread, 1 selects center spread |
| up_code_i | input | STEP_W | Upward excursion, negated two's-complement form |
| dn_code_i | input | STEP_W | Downward excursion, negated two's-complement form |
| dwell_i | input | DWELL_W | Ticks per step minus one |
| base_n_i | input | NDIV_W | Unmodulated divider value |
| ofs_o | output | STEP_W+1 | Current signed offset |
| div_n_o | output | NDIV_W | Modulated divider value |

## Verification
The bench drives the extreme code values (1000, 0000 and 1111). A decoder that treats the field as plain unsigned, or that sign-extends it wrongly, would stop at the wrong depth or never leave zero. It probes the turnaround points. A design that held one extra step at a peak, or overshot a limit by one, would break the expected triangle. It toggles the enable and the mode in mid-ramp and changes the base between boundaries. These catch a design that jumps early, fails to restart downward, or lets the base reach the output before the boundary. A dwell of 2, with idle cycles between ticks, exposes an off-by-one in the dwell count.

// File: rtl/ssm_pkg.sv
`timescale 1ns/1ps
package ssm_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } ssm_dir_e;
endpackage

// File: rtl/ssm_dwell_timer.sv
`timescale 1ns/1ps
module ssm_dwell_timer #(
   parameter int DWELL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [DWELL_W-1:0] dwell_i,
   output logic               step_o
);
   logic [DWELL_W-1:0] cnt_q;

   // ">=" keeps a lowered dwell value from letting the counter run past it
   assign step_o = tick_i && (cnt_q >= dwell_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= step_o ? '0 : cnt_q + DWELL_W'(1);
   end

   // R3: the counter only moves on a tick
   p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/ssm_limit_decode.sv
`timescale 1ns/1ps
module ssm_limit_decode #(
   parameter int STEP_W = 4,
   localparam int OFS_W = STEP_W + 1
) (
   input  logic                    center_i,
   input  logic [STEP_W-1:0]       up_code_i,
   input  logic [STEP_W-1:0]       dn_code_i,
   output logic signed [OFS_W-1:0] upper_o,
   output logic signed [OFS_W-1:0] lower_o
);
   logic [STEP_W-1:0] code [2];
   logic [STEP_W-1:0] mag  [2];

   assign code[0] = up_code_i;
   assign code[1] = dn_code_i;

   // each field holds the negated magnitude; negate again to recover it
   for (genvar g = 0; g < 2; g++) begin : g_field
      assign mag[g] = STEP_W'(~code[g]) + STEP_W'(1);
   end

   assign upper_o = center_i ? $signed({1'b0, mag[0]}) : '0;
   assign lower_o = -$signed({1'b0, mag[1]});
endmodule

// File: rtl/ssm_tri_seq.sv
`timescale 1ns/1ps
module ssm_tri_seq
   import ssm_pkg::*;
#(
   parameter int STEP_W = 4,
   localparam int OFS_W = STEP_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step_i,
   input  logic                    enable_i,
   input  logic                    center_i,
   input  logic signed [OFS_W-1:0] upper_i,
   input  logic signed [OFS_W-1:0] lower_i,
   output logic signed [OFS_W-1:0] ofs_o
);
   localparam logic signed [OFS_W-1:0] ONE  = 1;
   localparam logic signed [OFS_W-1:0] ZERO = 0;

   logic signed [OFS_W-1:0] ofs_q, ofs_d;
   ssm_dir_e                dir_q, dir_d;
   logic                    mode_q, mode_d;
   logic                    go_down;

   always_comb begin
      ofs_d   = ofs_q;
      dir_d   = dir_q;
      mode_d  = mode_q;
      go_down = (dir_q == DIR_DOWN);
      if (!enable_i || (center_i != mode_q)) begin
         ofs_d  = ZERO;
         dir_d  = DIR_DOWN;
         mode_d = center_i;
      end else begin
         // turn around on the boundary that finds the offset at a limit
         if (go_down && (ofs_q <= lower_i))
            go_down = 1'b0;
         else if (!go_down && (ofs_q >= upper_i))
            go_down = 1'b1;
         if (go_down && (ofs_q > lower_i))
            ofs_d = ofs_q - ONE;
         else if (!go_down && (ofs_q < upper_i))
            ofs_d = ofs_q + ONE;
         dir_d = go_down ? DIR_DOWN : DIR_UP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q  <= ZERO;
         dir_q  <= DIR_DOWN;
         mode_q <= 1'b0;
      end else if (step_i) begin
         ofs_q  <= ofs_d;
         dir_q  <= dir_d;
         mode_q <= mode_d;
      end
   end

   assign ofs_o = ofs_q;

   // R3: the offset moves only on a step boundary
   p_ofs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(ofs_q));
   // R4: in down-spread mode the offset never goes above zero
   p_down_nonpos_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (ofs_q <= ZERO));
   // R5: an enabled step in the current mode moves by at most one unit
   p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && enable_i && (center_i == mode_q)) |=>
      ((ofs_q == $past(ofs_q) + ONE) || (ofs_q == $past(ofs_q) - ONE) ||
       (ofs_q == $past(ofs_q))));
   // R6: a boundary with modulation off yields zero
   p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !enable_i) |=> (ofs_q == ZERO));
   // R7: a mode change zeroes the offset and restarts downward
   p_mode_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && enable_i && (center_i != mode_q)) |=>
      ((ofs_q == ZERO) && (dir_q == DIR_DOWN)));
endmodule

// File: rtl/ssm_div_out.sv
`timescale 1ns/1ps
module ssm_div_out #(
   parameter int NDIV_W = 11,
   parameter int OFS_W  = 5,
   parameter int RST_N  = 890
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step_i,
   input  logic [NDIV_W-1:0]       base_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   output logic [NDIV_W-1:0]       div_n_o
);
   logic [NDIV_W-1:0] base_q;
   logic [NDIV_W-1:0] ofs_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= NDIV_W'(RST_N);
      else if (step_i)
         base_q <= base_i;
   end

   assign ofs_ext = {{(NDIV_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
   assign div_n_o = base_q + ofs_ext;

   // R8: the divider value changes only after a step boundary
   p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(div_n_o));
endmodule

// File: rtl/ss_divider_mod.sv
`timescale 1ns/1ps
module ss_divider_mod #(
   parameter int STEP_W  = 4,
   parameter int DWELL_W = 6,
   parameter int NDIV_W  = 11,
   parameter int RST_N   = 890,
   localparam int OFS_W  = STEP_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    ss_en_i,
   input  logic                    center_i,
   input  logic [STEP_W-1:0]       up_code_i,
   input  logic [STEP_W-1:0]       dn_code_i,
   input  logic [DWELL_W-1:0]      dwell_i,
   input  logic [NDIV_W-1:0]       base_n_i,
   output logic signed [OFS_W-1:0] ofs_o,
   output logic [NDIV_W-1:0]       div_n_o
);
   if (STEP_W < 2 || STEP_W > 8) begin : g_bad_step
      $error("STEP_W must lie in 2..8");
   end
   if (NDIV_W <= OFS_W) begin : g_bad_ndiv
      $error("NDIV_W must exceed STEP_W+1");
   end
   if (DWELL_W < 1) begin : g_bad_dwell
      $error("DWELL_W must be at least 1");
   end

   logic                    step;
   logic signed [OFS_W-1:0] upper, lower;

   ssm_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dwell_i(dwell_i),
      .step_o(step));

   ssm_limit_decode #(.STEP_W(STEP_W)) u_limits (
      .center_i(center_i), .up_code_i(up_code_i), .dn_code_i(dn_code_i),
      .upper_o(upper), .lower_o(lower));

   ssm_tri_seq #(.STEP_W(STEP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .step_i(step), .enable_i(ss_en_i),
      .center_i(center_i), .upper_i(upper), .lower_i(lower), .ofs_o(ofs_o));

   ssm_div_out #(.NDIV_W(NDIV_W), .OFS_W(OFS_W), .RST_N(RST_N)) u_out (
      .clk(clk), .rst_n(rst_n), .step_i(step), .base_i(base_n_i),
      .ofs_i(ofs_o), .div_n_o(div_n_o));
endmodule

// File: tb/sim_ss_divider_mod.sv
`timescale 1ns/1ps
module sim_ss_divider_mod;
   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, en = 1'b1, cen = 1'b0;
   logic [3:0] up0 = '0, dn0 = 4'hB;
   logic [5:0] up1 = '0, dn1 = 6'h0B;
   logic [5:0] dwell = '0;
   logic [10:0] base = 11'd890;
   logic signed [4:0] ofs0;
   logic signed [6:0] ofs1;
   logic [10:0] div0, div1;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   ss_divider_mod #(.STEP_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .ss_en_i(en), .center_i(cen),
      .up_code_i(up0), .dn_code_i(dn0), .dwell_i(dwell), .base_n_i(base),
      .ofs_o(ofs0), .div_n_o(div0));

   ss_divider_mod #(.STEP_W(6)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .ss_en_i(en), .center_i(cen),
      .up_code_i(up1), .dn_code_i(dn1), .dwell_i(dwell), .base_n_i(base),
      .ofs_o(ofs1), .div_n_o(div1));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; en = 1'b1; cen = 1'b0;
      up0 = '0; dn0 = 4'hB; up1 = '0; dn1 = 6'h0B; dwell = '0; base = 11'd890;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // called at a falling edge; returns at a falling edge after the tick edge
   task automatic pulse();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 offset after reset", int'(ofs0), 0);
      chk("R1 divider after reset", int'(div0), 890);
      chk("R1 wide offset after reset", int'(ofs1), 0);
      chk("R1 wide divider after reset", int'(div1), 890);
      pulse(); pulse();
      chk("R1 offset moved before reset", int'(ofs0), -2);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 offset while reset held", int'(ofs0), 0);
      chk("R1 divider while reset held", int'(div0), 890);
      rst_n = 1'b1;
   endtask

   task automatic t_down();
      int e[7] = '{-1, -2, -3, -2, -1, 0, -1};
      do_reset();
      dn0 = 4'b1101;
      foreach (e[i]) begin
         pulse();
         chk("R4 down-spread offset", int'(ofs0), e[i]);
         chk("R8 divider is base plus offset", int'(div0), 890 + e[i]);
      end
   endtask

   task automatic t_center();
      int e[10] = '{0, -1, -2, -1, 0, 1, 2, 1, 0, -1};
      do_reset();
      cen = 1'b1; up0 = 4'b1110; dn0 = 4'b1110;
      foreach (e[i]) begin
         pulse();   // first boundary adopts center mode (R7)
         chk("R5 center-spread offset", int'(ofs0), e[i]);
      end
   endtask

   task automatic t_dwell();
      int e[6] = '{0, 0, -1, -1, -1, -2};
      int f[3] = '{-2, -2, -3};
      do_reset();
      dwell = 6'd2;
      foreach (e[i]) begin
         pulse();
         chk("R3 dwell of 2 gives 3 ticks per step", int'(ofs0), e[i]);
      end
      repeat (10) @(negedge clk);
      chk("R3 no change without tick", int'(ofs0), -2);
      foreach (f[i]) begin
         pulse();
         chk("R3 counter restarted at boundary", int'(ofs0), f[i]);
      end
   endtask

   task automatic t_limits();
      do_reset();
      dn0 = 4'b1000;
      for (int i = 1; i <= 8; i++) begin
         pulse();
         chk("R2 code 1000 ramps to -8", int'(ofs0), -i);
      end
      pulse();
      chk("R2 turnaround after -8", int'(ofs0), -7);
      do_reset();
      dn0 = 4'b0000;
      for (int i = 0; i < 3; i++) begin
         pulse();
         chk("R2 code 0000 holds zero", int'(ofs0), 0);
      end
      do_reset();
      dn0 = 4'b1111;
      pulse(); chk("R2 code 1111 depth 1", int'(ofs0), -1);
      pulse(); chk("R2 code 1111 back to 0", int'(ofs0), 0);
      pulse(); chk("R2 code 1111 down again", int'(ofs0), -1);
   endtask

   task automatic t_disable();
      do_reset();
      dn0 = 4'b1101;
      pulse(); pulse();
      en = 1'b0;
      @(negedge clk);
      chk("R6 disable waits for boundary", int'(ofs0), -2);
      pulse(); chk("R6 zero after disable", int'(ofs0), 0);
      pulse(); chk("R6 stays zero while disabled", int'(ofs0), 0);
      chk("R6 divider at base while disabled", int'(div0), 890);
      en = 1'b1;
      pulse(); chk("R6 re-enable starts downward", int'(ofs0), -1);
   endtask

   task automatic t_mode();
      do_reset();
      dn0 = 4'b1101; up0 = 4'b1110;
      pulse(); pulse();
      cen = 1'b1;
      @(negedge clk);
      chk("R7 mode change waits for boundary", int'(ofs0), -2);
      pulse(); chk("R7 zero at mode change", int'(ofs0), 0);
      pulse(); chk("R7 restart downward", int'(ofs0), -1);
   endtask

   task automatic t_base();
      do_reset();
      dn0 = 4'b1101; dwell = 6'd2;
      pulse(); pulse(); pulse();
      chk("R8 divider after first step", int'(div0), 889);
      base = 11'd1000;
      pulse(); chk("R8 base held between boundaries", int'(div0), 889);
      pulse(); chk("R8 base still held", int'(div0), 889);
      pulse(); chk("R8 new base at boundary", int'(div0), 998);
   endtask

   task automatic t_wide();
      int e[8] = '{0, -1, -2, -1, 0, 1, 0, -1};
      do_reset();
      cen = 1'b1; up1 = 6'b111111; dn1 = 6'b111110;
      foreach (e[i]) begin
         pulse();
         chk("R9 wide center offset", int'(ofs1), e[i]);
         chk("R9 wide divider", int'(div1), 890 + e[i]);
      end
      do_reset();
      dn1 = 6'b111000;
      for (int i = 0; i < 8; i++) pulse();
      chk("R9 code 111000 depth 8", int'(ofs1), -8);
      chk("R9 wide divider at depth", int'(div1), 882);
   endtask

   initial begin
      t_reset();
      t_down();
      t_center();
      t_dwell();
      t_limits();
      t_disable();
      t_mode();
      t_base();
      t_wide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule